// File: doc/BRIEF.md
# Windowed Int8 Matrix Accumulator

This block is the multiply-accumulate engine behind a 256-bit vector unit. It holds an 8x8 array of 32-bit accumulators and updates it from two operand groups. The narrow group is eight 256-bit vectors presented together. The wide group is fetched one 256-bit register per tick: the block drives the register index and the vector register file returns that register's contents in the same cycle. A 32-bit control word gives a mode and a start/stop window. The window sets both how many ticks the operation runs and which words are used. The control word also carries, for each operand, a signed/unsigned select and a 9-bit signed bias that is added to every byte before multiplication.

Besides the windowed product, the block accepts two single-cycle commands. A plain load copies the narrow group into the accumulators. A transposed load copies it across the diagonal. The accumulator array is always visible on the output vector group.

The sequencer has three named states. IDLE waits for a command. RUN covers one state per tick of an accepted product. FIN shows the one-cycle completion pulse. Its transitions are:
- IDLE to RUN, on an accepted, valid product command.
- IDLE to FIN, on an accepted load, transposed load or rejected command.
- RUN to RUN, while the current tick is below the window stop.
- RUN to FIN, on the tick equal to the stop.
- FIN to IDLE, always.

Top module: `mm_window_acc`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every accumulator to zero and returns the sequencer to IDLE with `busy`, `done` and `err` low, also in the middle of an operation.
- R2: The control word fields are as follows. Bits [1:0] are the mode. Bits [6:2] are the window start and bits [11:7] the window stop. Bit 21 is the narrow sign select and [20:12] the narrow bias. Bit 31 is the wide sign select and [30:22] the wide bias. Each byte is extended as signed when its select is 1 and as unsigned when it is 0, then added to the signed 9-bit bias, giving a 10-bit value. Each product of two such values is sign-extended to 32 bits.
- R3: On product tick t, accumulator (i,j) gains the sum of four byte products. The narrow bytes come from word t of narrow vector i (vector i at bits i*256, word w at bits w*32, byte k at bits k*8). The wide bytes come from word j of wide register t. During tick t, `wide_idx` equals t, and the ticks run from start up to stop in order.
- R4: An accepted product command (`op`=0) raises `busy` in the cycle after acceptance and holds it for exactly stop-start+1 cycles. A single-cycle `done` follows in the next cycle, with `busy` low.
- R5: A start request is ignored unless the sequencer is in IDLE, that is, while `busy` or `done` is high.
- R6: A product command whose stop is below its start, or whose stop exceeds 7, is rejected. It causes no busy cycle, gives `done` and `err` together in the cycle after acceptance, and leaves the accumulators unchanged.
- R7: A product command with a nonzero mode, and any command with `op`=3, is rejected in the same way as R6.
- R8: A load command (`op`=1) sets accumulator (i,j) to word j of narrow vector i at the accepting edge. `done` rises in the next cycle with `err` low and no busy cycle.
- R9: A transposed load command (`op`=2) sets accumulator (j,i) to word j of narrow vector i, with the same timing as R8.
- R10: `acc_out` shows accumulator (i,j) at bits (i*8+j)*32 at all times.
- R11: Accumulation wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command request, accepted in IDLE |
| op | input | 2 | Command: 0 product, 1 load, 2 transposed load, 3 reserved |
| ctrl | input | 32 | Control word (mode, window, signs, biases) |
| narrow_in | input | 2048 | Narrow group: eight 256-bit vectors, held during the operation |
| wide_in | input | 256 | Wide register selected by `wide_idx`, same cycle |
| wide_idx | output | 3 | Wide register index for the current tick |
| busy | output | 1 | Product ticks in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command, valid with `done` |
| acc_out | output | 2048 | Accumulator array, row-major |

## Verification
The bench drives inputs and samples outputs on the falling edge. A command raised before edge E0 gives its first product tick in the half cycle after E0. Each of the n ticks is checked for `busy` and `wide_idx` at its own falling edge. `done`, `err` and the full accumulator array are checked one falling edge later, and `done` is checked low on the next. Loads and rejected commands skip the tick phase, so their `done`, `err` and array are checked at the first falling edge after acceptance. The bench keeps start requests raised through the tick and done cycles to show they leave the result untouched, and it compares every array against a bench-side byte-level model.

// File: rtl/mmw_pkg.sv
package mmw_pkg;

    typedef enum logic [1:0] {
        OP_MAC   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_TLOAD = 2'd2,
        OP_RSVD  = 2'd3
    } mmw_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_FIN
    } mmw_state_e;

    typedef struct packed {
        logic       w_sgn;
        logic [8:0] w_bias;
        logic       n_sgn;
        logic [8:0] n_bias;
        logic [4:0] stop;
        logic [4:0] start;
        logic [1:0] mode;
    } mmw_ctrl_t;

    typedef struct packed {
        logic       n_sgn;
        logic [8:0] n_bias;
        logic       w_sgn;
        logic [8:0] w_bias;
    } mmw_opcfg_t;

    function automatic logic signed [9:0] ext_bias(input logic [7:0] d,
                                                   input logic sgn,
                                                   input logic [8:0] bias);
        logic signed [9:0] x;
        logic signed [9:0] y;
        x = sgn ? {{2{d[7]}}, d} : {2'b00, d};
        y = {bias[8], bias};
        return x + y;
    endfunction

endpackage

// File: rtl/mmw_seq.sv
module mmw_seq
    import mmw_pkg::*;
#(
    parameter int LANES = 8,
    localparam int IDXW = $clog2(LANES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [31:0]     ctrl_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic [IDXW-1:0] tick_o,
    output logic            mac_en_o,
    output logic            ld_en_o,
    output logic            tld_en_o,
    output mmw_opcfg_t      cfg_o
);

    mmw_state_e      st_q, st_d;
    logic [IDXW-1:0] tick_q, stop_q;
    logic            err_q;
    mmw_opcfg_t      cfg_q;
    mmw_ctrl_t       cin;
    mmw_op_e         opc;
    logic            accept, win_ok, bad, last;

    assign cin    = ctrl_i;
    assign opc    = mmw_op_e'(op_i);
    assign accept = start_i && (st_q == S_IDLE);
    assign win_ok = (cin.start <= cin.stop) && (cin.stop < 5'(LANES));
    assign bad    = (opc == OP_RSVD) ||
                    ((opc == OP_MAC) && ((cin.mode != 2'd0) || !win_ok));
    assign last   = (tick_q == stop_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (accept) st_d = (opc == OP_MAC && !bad) ? S_RUN : S_FIN;
            S_RUN:  if (last)   st_d = S_FIN;
            S_FIN:              st_d = S_IDLE;
            default:            st_d = S_IDLE;
        endcase
    end

    // state register and command latches
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            tick_q <= '0;
            stop_q <= '0;
            err_q  <= 1'b0;
            cfg_q  <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                tick_q <= cin.start[IDXW-1:0];
                stop_q <= cin.stop[IDXW-1:0];
                err_q  <= bad;
                cfg_q  <= '{n_sgn: cin.n_sgn, n_bias: cin.n_bias,
                            w_sgn: cin.w_sgn, w_bias: cin.w_bias};
            end else if (st_q == S_RUN && !last) begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o   = (st_q == S_RUN);
        done_o   = (st_q == S_FIN);
        err_o    = (st_q == S_FIN) && err_q;
        mac_en_o = (st_q == S_RUN);
        ld_en_o  = accept && (opc == OP_LOAD);
        tld_en_o = accept && (opc == OP_TLOAD);
        tick_o   = tick_q;
        cfg_o    = cfg_q;
    end

    a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last) |=> (busy_o && tick_o == $past(tick_o) + 1'b1));
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
    a_r6_no_err_after_run: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !err_o);

endmodule

// File: rtl/mmw_dot4.sv
module mmw_dot4
    import mmw_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int NB = WORD_W / 8
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  mmw_opcfg_t        cfg_i,
    output logic [WORD_W-1:0] sum_o
);

    logic [WORD_W-1:0] prod [NB];

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic signed [9:0]  ea, eb;
        logic signed [19:0] p;
        assign ea = ext_bias(a_i[k*8 +: 8], cfg_i.n_sgn, cfg_i.n_bias);
        assign eb = ext_bias(b_i[k*8 +: 8], cfg_i.w_sgn, cfg_i.w_bias);
        assign p  = ea * eb;
        assign prod[k] = {{(WORD_W-20){p[19]}}, p};
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NB; k++) sum_o = sum_o + prod[k];
    end

endmodule

// File: rtl/mmw_acc_bank.sv
module mmw_acc_bank #(
    parameter int LANES  = 8,
    parameter int WORD_W = 32,
    localparam int TOT_W = LANES * LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mac_en_i,
    input  logic             ld_en_i,
    input  logic             tld_en_i,
    input  logic [TOT_W-1:0] inc_i,
    input  logic [TOT_W-1:0] src_i,
    output logic [TOT_W-1:0] acc_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            localparam int SELF = (i * LANES + j) * WORD_W;
            localparam int TRN  = (j * LANES + i) * WORD_W;
            logic [WORD_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst)           cell_q <= '0;
                else if (ld_en_i)  cell_q <= src_i[SELF +: WORD_W];
                else if (tld_en_i) cell_q <= src_i[TRN +: WORD_W];
                else if (mac_en_i) cell_q <= cell_q + inc_i[SELF +: WORD_W];
            end
            assign acc_o[SELF +: WORD_W] = cell_q;
        end
    end

    a_r6_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !(mac_en_i || ld_en_i || tld_en_i) |=> $stable(acc_o));

endmodule

// File: rtl/mm_window_acc.sv
module mm_window_acc
    import mmw_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int WORD_W = 32,
    localparam int VEC_W = LANES * WORD_W,
    localparam int GRP_W = LANES * VEC_W,
    localparam int IDXW  = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [31:0]      ctrl,
    input  logic [GRP_W-1:0] narrow_in,
    input  logic [VEC_W-1:0] wide_in,
    output logic [IDXW-1:0]  wide_idx,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [GRP_W-1:0] acc_out
);

    logic             mac_en, ld_en, tld_en;
    logic [IDXW-1:0]  tick;
    mmw_opcfg_t       cfg;
    logic [GRP_W-1:0] inc;

    mmw_seq #(.LANES(LANES)) u_seq (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .ctrl_i(ctrl),
        .busy_o(busy), .done_o(done), .err_o(err), .tick_o(tick),
        .mac_en_o(mac_en), .ld_en_o(ld_en), .tld_en_o(tld_en), .cfg_o(cfg)
    );

    assign wide_idx = tick;

    for (genvar i = 0; i < LANES; i++) begin : g_row
        logic [WORD_W-1:0] nword;
        assign nword = narrow_in[i*VEC_W + int'(tick)*WORD_W +: WORD_W];
        for (genvar j = 0; j < LANES; j++) begin : g_col
            mmw_dot4 #(.WORD_W(WORD_W)) u_dot (
                .a_i(nword),
                .b_i(wide_in[j*WORD_W +: WORD_W]),
                .cfg_i(cfg),
                .sum_o(inc[(i*LANES+j)*WORD_W +: WORD_W])
            );
        end
    end

    mmw_acc_bank #(.LANES(LANES), .WORD_W(WORD_W)) u_bank (
        .clk(clk), .rst(rst), .mac_en_i(mac_en), .ld_en_i(ld_en),
        .tld_en_i(tld_en), .inc_i(inc), .src_i(narrow_in), .acc_o(acc_out)
    );

endmodule

// File: tb/mm_window_acc_bench.sv
module mm_window_acc_bench;

    localparam int L = 8, W = 32, VW = L * W, GW = L * VW;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [31:0]   ctrl = '0;
    logic [GW-1:0] narrow = '0;
    logic [VW-1:0] wide_mem [L];
    logic [VW-1:0] wide_in;
    logic [2:0]    wide_idx;
    logic          busy, done, err;
    logic [GW-1:0] acc_out;

    int checks = 0, fails = 0;
    int unsigned m_acc [L][L];

    always #2 clk = ~clk;

    assign wide_in = wide_mem[wide_idx];

    mm_window_acc u_mm_window_acc (
        .clk(clk), .rst(rst), .start(start), .op(op), .ctrl(ctrl),
        .narrow_in(narrow), .wide_in(wide_in), .wide_idx(wide_idx),
        .busy(busy), .done(done), .err(err), .acc_out(acc_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input string req);
        int bad = 0;
        logic [31:0] a1 = '0, e1 = '0;
        for (int i = 0; i < L; i++)
            for (int j = 0; j < L; j++)
                if (acc_out[(i*L+j)*W +: W] !== m_acc[i][j]) begin
                    if (bad == 0) begin a1 = acc_out[(i*L+j)*W +: W]; e1 = m_acc[i][j]; end
                    bad++;
                end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s acc words wrong=%0d first act=%h exp=%h", req, bad, a1, e1);
        end
    endtask

    function automatic logic [31:0] mk(input int md, input int s, input int e,
                                       input bit s1, input int b1, input bit s2, input int b2);
        return {s2, 9'(b2), s1, 9'(b1), 5'(e), 5'(s), 2'(md)};
    endfunction

    function automatic int ext(input logic [7:0] d, input logic s, input logic [8:0] b);
        int dv;
        dv = s ? int'($signed(d)) : int'({24'd0, d});
        return dv + int'($signed(b));
    endfunction

    function automatic logic [31:0] nword(input int i, input int w);
        return narrow[i*VW + w*W +: W];
    endfunction

    task automatic model(input logic [1:0] o, input logic [31:0] c);
        int st = int'(c[6:2]), sp = int'(c[11:7]);
        if (o == 2'd1) begin
            for (int i = 0; i < L; i++) for (int j = 0; j < L; j++) m_acc[i][j] = nword(i, j);
        end else if (o == 2'd2) begin
            for (int i = 0; i < L; i++) for (int j = 0; j < L; j++) m_acc[j][i] = nword(i, j);
        end else if (o == 2'd0 && c[1:0] == 2'd0 && st <= sp && sp < L) begin
            for (int t = st; t <= sp; t++)
                for (int i = 0; i < L; i++)
                    for (int j = 0; j < L; j++)
                        for (int k = 0; k < 4; k++) begin
                            int p;
                            p = ext(narrow[i*VW + t*W + k*8 +: 8], c[21], c[20:12]) *
                                ext(wide_mem[t][j*W + k*8 +: 8], c[31], c[30:22]);
                            m_acc[i][j] = m_acc[i][j] + 32'(p);
                        end
        end
    endtask

    // poke: keep requesting a load during the busy and done cycles (R5)
    task automatic cmd(input logic [1:0] o, input logic [31:0] c, input bit poke, input string tag);
        int st = int'(c[6:2]), sp = int'(c[11:7]);
        bit exp_err = (o == 2'd3) || (o == 2'd0 && (c[1:0] != 2'd0 || st > sp || sp >= L));
        int n = (o == 2'd0 && !exp_err) ? sp - st + 1 : 0;
        @(negedge clk);
        op = o; ctrl = c; start = 1'b1;
        model(o, c);
        @(negedge clk);
        start = poke;
        if (poke) op = 2'd1;
        for (int k = 0; k < n; k++) begin
            chk({tag, " R4 busy during tick"}, 64'(busy), 64'd1);
            chk({tag, " R3 wide_idx order"}, 64'(wide_idx), 64'(st + k));
            chk({tag, " R4 no done during tick"}, 64'(done), 64'd0);
            @(negedge clk);
        end
        chk({tag, " R4 done pulse"}, 64'(done), 64'd1);
        chk({tag, " R4 busy low at done"}, 64'(busy), 64'd0);
        chk({tag, " R6 R7 err flag"}, 64'(err), 64'(exp_err));
        chk_acc({tag, " R10 acc after command"});
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R5 no second done"}, 64'(done), 64'd0);
        chk({tag, " R5 stays idle"}, 64'(busy), 64'd0);
        chk_acc({tag, " R5 acc unchanged after ignored start"});
    endtask

    task automatic fill_rand();
        for (int b = 0; b < GW / 32; b++) narrow[b*32 +: 32] = $urandom;
        for (int r = 0; r < L; r++)
            for (int b = 0; b < VW / 32; b++) wide_mem[r][b*32 +: 32] = $urandom;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < L; i++) for (int j = 0; j < L; j++) m_acc[i][j] = 0;
        for (int r = 0; r < L; r++) wide_mem[r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 err after reset", 64'(err), 64'd0);
        chk_acc("R1 acc zero after reset");

        fill_rand();
        cmd(2'd1, 32'd0, 1'b0, "R8 load");
        fill_rand();
        cmd(2'd2, 32'd0, 1'b0, "R9 transposed load");
        cmd(2'd0, mk(0, 0, 0, 1, 0, 1, 0), 1'b0, "R2 single tick signed");
        cmd(2'd0, mk(0, 0, 7, 0, 37, 0, 511), 1'b0, "R2 full window unsigned bias");
        cmd(2'd0, mk(0, 3, 5, 1, 300, 0, 12), 1'b1, "R5 poke during run");
        cmd(2'd1, 32'd0, 1'b1, "R5 poke after load");
        cmd(2'd0, mk(0, 5, 2, 1, 0, 1, 0), 1'b0, "R6 stop below start");
        cmd(2'd0, mk(0, 2, 9, 1, 0, 1, 0), 1'b0, "R6 stop past seven");
        cmd(2'd0, mk(2, 0, 3, 1, 0, 1, 0), 1'b0, "R7 nonzero mode");
        cmd(2'd3, mk(0, 0, 3, 1, 0, 1, 0), 1'b0, "R7 reserved op");

        // wrap: preload large values then add large positive products (R11)
        for (int b = 0; b < GW / 32; b++) narrow[b*32 +: 32] = 32'h7FFF_FFF0;
        cmd(2'd1, 32'd0, 1'b0, "R11 preload");
        for (int b = 0; b < GW / 32; b++) narrow[b*32 +: 32] = 32'h7F7F_7F7F;
        for (int r = 0; r < L; r++) wide_mem[r] = {VW/8{8'hFF}};
        cmd(2'd0, mk(0, 0, 7, 1, 255, 0, 255), 1'b0, "R11 wrap");

        for (int it = 0; it < 40; it++) begin
            int st = $urandom % 8;
            int sp = st + ($urandom % (8 - st));
            int sel = $urandom % 10;
            logic [31:0] c = mk(0, st, sp, 1'($urandom), int'($urandom % 512),
                                1'($urandom), int'($urandom % 512));
            fill_rand();
            if (sel == 0) c = $urandom;
            cmd(sel == 1 ? 2'd1 : sel == 2 ? 2'd2 : 2'd0, c, 1'($urandom), "R2 R3 random");
        end

        // reset in the middle of a run (R1)
        fill_rand();
        cmd(2'd1, 32'd0, 1'b0, "R1 preload");
        @(negedge clk);
        op = 2'd0; ctrl = mk(0, 0, 7, 0, 0, 0, 0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < L; i++) for (int j = 0; j < L; j++) m_acc[i][j] = 0;
        chk("R1 busy cleared by mid-run reset", 64'(busy), 64'd0);
        chk("R1 done after mid-run reset", 64'(done), 64'd0);
        chk_acc("R1 acc cleared by mid-run reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule